// File: doc/BRIEF.md
# Microstep Translator Indexer

This block turns a step/direction command stream into two signed current setpoints for the two windings of a bipolar stepper motor. It keeps an electrical-angle index of 64 positions per electrical cycle. Each accepted rising edge of the step input moves the index forward or backward. The size of the move comes from a 3-bit resolution select, which offers full, half, quarter, eighth and sixteenth stepping. From the index, the block reads a quarter-wave sine table and drives an 8-bit magnitude with a separate polarity bit for each winding. Phase 1 follows the sine of the angle and phase 2 follows the cosine.

All command pins are asynchronous to the block clock, so each one passes through a synchronizer. A high or low level on the step pin counts only after it has held for a programmable number of clocks, which rejects glitches and pulses that are too short. A rehome pin returns the index to the home angle of 45 degrees, where both windings carry 70.71 % of full scale with positive polarity. A sleep pin switches both winding outputs off. A flag reports when the index is at home. The downstream current regulators and power stages consume the setpoints.

Top module: `stepper_indexer`

## Requirements
- R1: The resolution select is read as {res_sel_i[2], res_sel_i[1], res_sel_i[0]}. Code 000 moves the index 16 positions per step, 001 moves it 8, 010 moves it 4, 011 moves it 2 and 111 moves it 1. The unused codes 100, 101 and 110 behave like 000.
- R2: The index changes only on an accepted rising edge of step_i. With dir_i = 1 it increases, with dir_i = 0 it decreases, and in both cases it wraps modulo 64.
- R3: A rising step edge is accepted only when step_i has stayed high for at least MIN_PULSE clocks and, before that, stayed low for at least MIN_PULSE clocks. A high pulse of MIN_PULSE-1 clocks changes nothing. A low gap of MIN_PULSE-1 clocks between two high pulses merges them into a single step.
- R4: While rst_n is low, or while rehome_n_i is low, the index is forced to 8, the home angle, and step edges are ignored.
- R5: While sleep_n_i is low, drive_en_o is 0, and both magnitudes and both polarity bits are 0. Step edges that arrive during sleep are dropped, so the index is unchanged when the block wakes.
- R6: When awake, ph1_mag_o equals round(255·|sin(2π·i/64)|), where i is the index. ph1_neg_o is 1 exactly when the sine is negative and the magnitude is nonzero.
- R7: When awake, ph2_mag_o and ph2_neg_o follow the same rule as R6, using the cosine of the same index.
- R8: At index 4, 8 and 16 the phase-1 magnitude is 98, 180 and 255. These are the 38.27 %, 70.71 % and 100 % levels.
- R9: at_home_o is 1 exactly when the index equals 8.
- R10: On an accepted step, the index is first snapped to the nearest grid position p for the current resolution, where (p − 8) mod 64 is a multiple of the step size, with ties going to the larger offset. The step is then applied from p. When the index is already on the grid, this reduces to a plain step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | Step command; a qualified rising edge moves the index |
| dir_i | input | 1 | Direction: 1 increases the index, 0 decreases it |
| res_sel_i | input | 3 | Resolution select code |
| rehome_n_i | input | 1 | Active-low return to the home angle |
| sleep_n_i | input | 1 | Active-low sleep; turns both winding outputs off |
| drive_en_o | output | 1 | Winding outputs enabled |
| ph1_mag_o | output | 8 | Phase-1 current magnitude, 255 = full scale |
| ph1_neg_o | output | 1 | Phase-1 polarity, 1 = negative |
| ph2_mag_o | output | 8 | Phase-2 current magnitude, 255 = full scale |
| ph2_neg_o | output | 1 | Phase-2 polarity, 1 = negative |
| at_home_o | output | 1 | Index is at the home angle |

## Verification
The hardest case to reach from the pins is a coarse step taken while the index sits between grid points. That only happens after fine steps have been taken and the select code has then been changed. The round-half tie needs the index exactly halfway between two coarse grid points. The stimulus first walks all 64 positions in sixteenth mode in both directions. It then sets up a misaligned position and a tie position on purpose. Finally it runs a long seeded sequence that mixes all select codes, including an unused one, with both directions, and compares every result against a sine/cosine model computed in floating point.

// File: rtl/stepidx_pkg.sv
// Shared types and helpers for the microstep indexer.
// Assumes 64 index positions per electrical cycle, 16 of them per quarter wave.
package stepidx_pkg;

    localparam int IDX_W   = 6;
    localparam int QTR_POS = 16;
    localparam int MAG_W   = 8;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [MAG_W-1:0] mag_t;

    localparam idx_t HOME_IDX = idx_t'(QTR_POS / 2);

    // Value = log2 of the number of sixteenth positions per step, counted downward.
    typedef enum logic [2:0] {
        RES_FULL      = 3'd0,
        RES_HALF      = 3'd1,
        RES_QUARTER   = 3'd2,
        RES_EIGHTH    = 3'd3,
        RES_SIXTEENTH = 3'd4
    } res_t;

    // Map the 3-pin select code to a resolution; unused codes select full step.
    function automatic res_t decode_res(input logic [2:0] sel);
        case (sel)
            3'b000:  return RES_FULL;
            3'b001:  return RES_HALF;
            3'b010:  return RES_QUARTER;
            3'b011:  return RES_EIGHTH;
            3'b111:  return RES_SIXTEENTH;
            default: return RES_FULL;
        endcase
    endfunction

    // Index positions moved per step for a resolution.
    function automatic idx_t step_size(input res_t r);
        return idx_t'(QTR_POS) >> r;
    endfunction

    // round(255 * sin(k * 90deg / 16)) for k = 0..16.
    function automatic mag_t quarter_sine(input logic [4:0] k);
        case (k)
            5'd0:    return 8'd0;
            5'd1:    return 8'd25;
            5'd2:    return 8'd50;
            5'd3:    return 8'd74;
            5'd4:    return 8'd98;
            5'd5:    return 8'd120;
            5'd6:    return 8'd142;
            5'd7:    return 8'd162;
            5'd8:    return 8'd180;
            5'd9:    return 8'd197;
            5'd10:   return 8'd212;
            5'd11:   return 8'd225;
            5'd12:   return 8'd236;
            5'd13:   return 8'd244;
            5'd14:   return 8'd250;
            5'd15:   return 8'd254;
            default: return 8'd255;
        endcase
    endfunction

endpackage

// File: rtl/stepidx_sync.sv
// Multi-stage level synchronizer for asynchronous command pins.
// Assumes each bit is an independent level; no bus coherency is implied.
module stepidx_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] pipe [STAGES];

    // Shift the pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= d_i;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/stepidx_pulse_qual.sv
// Step pulse qualifier: a level is accepted only after it has held for
// MIN_PULSE consecutive clocks; emits a one-clock pulse per accepted rise.
// Assumes lvl_i is already synchronous to clk.
module stepidx_pulse_qual #(
    parameter int MIN_PULSE = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);

    localparam int             CNT_W    = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_PULSE - 1);

    logic             filt;
    logic             filt_q;
    logic [CNT_W-1:0] run_cnt;

    // Count clocks the input disagrees with the filtered level; adopt it at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt    <= 1'b0;
            run_cnt <= '0;
        end else if (lvl_i == filt) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_LAST) begin
            filt    <= lvl_i;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Delay the filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) filt_q <= 1'b0;
        else        filt_q <= filt;
    end

    assign rise_o = filt & ~filt_q;

    // R3
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

    // R3
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) |-> (filt == $past(lvl_i)));

endmodule

// File: rtl/stepidx_angle.sv
// Electrical-angle index register. On a qualified step it snaps the index to
// the grid of the current resolution (home-aligned, ties upward), then moves
// one step in the commanded direction. Rehome forces the home angle.
// Assumes step_evt_i is a single-cycle pulse.
module stepidx_angle import stepidx_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic step_evt_i,
    input  logic fwd_i,
    input  res_t res_i,
    input  logic rehome_i,
    input  logic awake_i,
    output idx_t idx_o
);

    idx_t inc;
    idx_t grid_mask;
    idx_t rel;
    idx_t snapped;
    idx_t next_idx;

    // Compute the snapped position and the next index for this step.
    always_comb begin
        inc       = step_size(res_i);
        grid_mask = inc - idx_t'(1);
        rel       = idx_o - HOME_IDX;
        snapped   = (rel + (inc >> 1)) & ~grid_mask;
        next_idx  = fwd_i ? (snapped + inc + HOME_IDX)
                          : (snapped - inc + HOME_IDX);
    end

    // Hold, rehome or advance the index.
    always_ff @(posedge clk) begin
        if (!rst_n || rehome_i) idx_o <= HOME_IDX;
        else if (step_evt_i && awake_i) idx_o <= next_idx;
    end

    // R10
    grid_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_evt_i && awake_i && !rehome_i) |=>
            (((idx_o - HOME_IDX) & $past(grid_mask)) == idx_t'(0)));

    // R5
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!awake_i && !rehome_i) |=> (idx_o == $past(idx_o)));

    // R4
    rehome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rehome_i |=> (idx_o == HOME_IDX));

endmodule

// File: rtl/stepidx_phase_lut.sv
// Quarter-wave sine lookup for one winding. PHASE_OFS shifts the angle by
// index positions (16 turns sine into cosine). Output is magnitude plus sign.
// Assumes 64 positions per cycle; zero magnitude is reported as positive.
module stepidx_phase_lut import stepidx_pkg::*; #(
    parameter int PHASE_OFS = 0
) (
    input  idx_t idx_i,
    output mag_t mag_o,
    output logic neg_o
);

    idx_t       angle;
    logic [4:0] qtr_pos;

    // Fold the angle into the first quadrant and read the table.
    always_comb begin
        angle   = idx_i + idx_t'(PHASE_OFS);
        qtr_pos = angle[4] ? (5'd16 - {1'b0, angle[3:0]}) : {1'b0, angle[3:0]};
        mag_o   = quarter_sine(qtr_pos);
        neg_o   = angle[5] && (mag_o != '0);
    end

endmodule

// File: rtl/stepper_indexer.sv
// Step/direction microstep indexer top. Synchronizes the command pins,
// qualifies step pulses, keeps the electrical angle and produces registered
// sine/cosine current setpoints for two windings.
// Assumes all command pins are asynchronous to clk.
module stepper_indexer import stepidx_pkg::*; #(
    parameter int MIN_PULSE   = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             dir_i,
    input  logic [2:0]       res_sel_i,
    input  logic             rehome_n_i,
    input  logic             sleep_n_i,
    output logic             drive_en_o,
    output logic [MAG_W-1:0] ph1_mag_o,
    output logic             ph1_neg_o,
    output logic [MAG_W-1:0] ph2_mag_o,
    output logic             ph2_neg_o,
    output logic             at_home_o
);

    localparam int NUM_PH = 2;

    logic       step_s;
    logic [3:0] ctl_s;
    logic [1:0] pwr_s;
    logic       step_evt;
    logic       awake;
    logic       rehome;
    res_t       res;
    idx_t       idx;
    mag_t       lut_mag [NUM_PH];
    logic       lut_neg [NUM_PH];

    stepidx_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_step_sync (
        .clk(clk), .rst_n(rst_n), .d_i(step_i), .q_o(step_s)
    );

    stepidx_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d_i({dir_i, res_sel_i}), .q_o(ctl_s)
    );

    stepidx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_pwr_sync (
        .clk(clk), .rst_n(rst_n), .d_i({sleep_n_i, rehome_n_i}), .q_o(pwr_s)
    );

    stepidx_pulse_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
        .clk(clk), .rst_n(rst_n), .lvl_i(step_s), .rise_o(step_evt)
    );

    assign awake  = pwr_s[1];
    assign rehome = !pwr_s[0];
    assign res    = decode_res(ctl_s[2:0]);

    stepidx_angle u_angle (
        .clk(clk), .rst_n(rst_n), .step_evt_i(step_evt), .fwd_i(ctl_s[3]),
        .res_i(res), .rehome_i(rehome), .awake_i(awake), .idx_o(idx)
    );

    for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
        stepidx_phase_lut #(.PHASE_OFS(g * QTR_POS)) u_lut (
            .idx_i(idx), .mag_o(lut_mag[g]), .neg_o(lut_neg[g])
        );
    end

    // Register the winding setpoints, gated off while asleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_en_o <= 1'b0;
            ph1_mag_o  <= '0;
            ph1_neg_o  <= 1'b0;
            ph2_mag_o  <= '0;
            ph2_neg_o  <= 1'b0;
        end else begin
            drive_en_o <= awake;
            ph1_mag_o  <= awake ? lut_mag[0] : '0;
            ph1_neg_o  <= awake && lut_neg[0];
            ph2_mag_o  <= awake ? lut_mag[1] : '0;
            ph2_neg_o  <= awake && lut_neg[1];
        end
    end

    // Register the home indication.
    always_ff @(posedge clk) begin
        if (!rst_n) at_home_o <= 1'b0;
        else        at_home_o <= (idx == HOME_IDX);
    end

    // R5
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |=> (!drive_en_o && ph1_mag_o == '0 && ph2_mag_o == '0
                    && !ph1_neg_o && !ph2_neg_o));

    // R7
    quadrature_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en_o && ph1_mag_o == 8'd255) |-> (ph2_mag_o == 8'd0));

    // R9
    home_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en_o && at_home_o) |-> (ph1_mag_o == 8'd180 && ph2_mag_o == 8'd180
                                       && !ph1_neg_o && !ph2_neg_o));

endmodule

// File: tb/test_stepper_indexer.sv
module test_stepper_indexer;

    localparam int CLK_PERIOD = 10;
    localparam int MINP       = 3;

    logic       clk = 1'b0;
    logic       rst_n, step_i, dir_i, rehome_n_i, sleep_n_i;
    logic [2:0] res_sel_i;
    logic       drive_en_o, ph1_neg_o, ph2_neg_o, at_home_o;
    logic [7:0] ph1_mag_o, ph2_mag_o;

    int n_chk = 0;
    int n_bad = 0;
    int model = 8;
    bit done  = 0;

    stepper_indexer #(.MIN_PULSE(MINP)) i_stepper_indexer (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .dir_i(dir_i),
        .res_sel_i(res_sel_i), .rehome_n_i(rehome_n_i), .sleep_n_i(sleep_n_i),
        .drive_en_o(drive_en_o), .ph1_mag_o(ph1_mag_o), .ph1_neg_o(ph1_neg_o),
        .ph2_mag_o(ph2_mag_o), .ph2_neg_o(ph2_neg_o), .at_home_o(at_home_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int inc_of(input logic [2:0] sel);
        case (sel)
            3'b000:  return 16;
            3'b001:  return 8;
            3'b010:  return 4;
            3'b011:  return 2;
            3'b111:  return 1;
            default: return 16;
        endcase
    endfunction

    function automatic int next_idx(input int idx, input bit fwd, input logic [2:0] sel);
        int inc, a, r;
        inc = inc_of(sel);
        a   = (idx - 8 + 64) % 64;
        r   = (((a + inc / 2) / inc) * inc) % 64;
        return fwd ? (r + 8 + inc) % 64 : (r + 8 + 64 - inc) % 64;
    endfunction

    task automatic expect_phase(input int idx, input int ph, output int m, output bit n);
        real v;
        v = $sin(6.283185307179586 * real'(idx + 16 * ph) / 64.0);
        m = int'($floor(((v < 0.0) ? -v : v) * 255.0 + 0.5));
        n = (v < 0.0) && (m != 0);
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        int m1, m2;
        bit n1, n2;
        expect_phase(model, 0, m1, n1);
        expect_phase(model, 1, m2, n2);
        n_chk++;
        if (!(drive_en_o === 1'b1 && ph1_mag_o == m1 && ph1_neg_o === n1 &&
              ph2_mag_o == m2 && ph2_neg_o === n2 && at_home_o === (model == 8))) begin
            n_bad++;
            $display("FAIL %s: actual en=%0d p1=%0d/%0d p2=%0d/%0d home=%0d expected en=1 p1=%0d/%0d p2=%0d/%0d home=%0d (index %0d)",
                     tag, drive_en_o, ph1_mag_o, ph1_neg_o, ph2_mag_o, ph2_neg_o, at_home_o,
                     m1, n1, m2, n2, (model == 8), model);
        end
    endtask

    task automatic do_pulse(input int hi, input int lo);
        step_i = 1'b1;
        tick(hi);
        step_i = 1'b0;
        tick(lo);
    endtask

    task automatic step_once(input bit fwd, input logic [2:0] sel, input string tag);
        dir_i     = fwd;
        res_sel_i = sel;
        tick(3);
        do_pulse(MINP, MINP);
        tick(MINP + 8);
        model = next_idx(model, fwd, sel);
        check_state(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [2:0] sels [6];
        sels = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b111, 3'b101};
        rst_n = 1'b0; step_i = 1'b0; dir_i = 1'b1; res_sel_i = 3'b000;
        rehome_n_i = 1'b1; sleep_n_i = 1'b1;
        tick(4);
        // R4 reset state: outputs held off during reset
        check_val("R4 en during reset", drive_en_o, 0);
        rst_n = 1'b1;
        tick(5);
        check_state("R4 home after reset");
        check_val("R9 home flag after reset", at_home_o, 1);

        // R2 R6 R7 R8 R9: full sweep forward in sixteenth mode
        for (int i = 0; i < 64; i++) begin
            step_once(1'b1, 3'b111, "R2/R6/R7 fwd sweep");
            if (model == 4)  check_val("R8 38.27% level", ph1_mag_o, 98);
            if (model == 8)  check_val("R8 70.71% level", ph1_mag_o, 180);
            if (model == 16) check_val("R8 100% level", ph1_mag_o, 255);
        end
        // R2 reverse sweep
        for (int i = 0; i < 64; i++) step_once(1'b0, 3'b111, "R2/R6/R7 rev sweep");

        // R1 every select code, both directions
        for (int s = 0; s < 6; s++) begin
            for (int i = 0; i < 8; i++) step_once(1'b1, sels[s], "R1 fwd by code");
            for (int i = 0; i < 8; i++) step_once(1'b0, sels[s], "R1 rev by code");
        end

        // R10 misaligned index then full step: 8 -> 11 -> 24
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(5); model = 8;
        for (int i = 0; i < 3; i++) step_once(1'b1, 3'b111, "R10 setup");
        step_once(1'b1, 3'b000, "R10 snap nearest");
        check_val("R10 misaligned full step", model, 24);
        // R10 tie: index 16 in full mode rounds up to 24, then forward to 40
        for (int i = 0; i < 8; i++) step_once(1'b0, 3'b111, "R10 setup tie");
        step_once(1'b1, 3'b000, "R10 tie upward");
        check_val("R10 tie target", model, 40);

        // R1 R10 seeded mix of codes and directions
        for (int i = 0; i < 300; i++) begin
            int k;
            bit d;
            k = $urandom_range(5, 0);
            d = 1'($urandom_range(1, 0));
            step_once(d, sels[k], "R10/R1 mixed");
        end

        // R3 short high pulse ignored
        dir_i = 1'b1; res_sel_i = 3'b111; tick(3);
        do_pulse(MINP - 1, MINP + 10);
        check_state("R3 short high ignored");
        // R3 short low gap merges two pulses into one step
        do_pulse(MINP, MINP - 1);
        do_pulse(MINP, MINP + 10);
        model = next_idx(model, 1'b1, 3'b111);
        check_state("R3 short gap merged");

        // R5 sleep: outputs off, steps dropped
        sleep_n_i = 1'b0;
        tick(6);
        check_val("R5 en in sleep", drive_en_o, 0);
        check_val("R5 mags in sleep", ph1_mag_o + ph2_mag_o, 0);
        check_val("R5 signs in sleep", ph1_neg_o + ph2_neg_o, 0);
        do_pulse(MINP, MINP);
        do_pulse(MINP, MINP);
        tick(4);
        sleep_n_i = 1'b1;
        tick(6);
        check_state("R5 index kept across sleep");

        // R4 rehome with a step during it
        step_once(1'b1, 3'b111, "R4 move away");
        rehome_n_i = 1'b0;
        tick(3);
        do_pulse(MINP, MINP);
        tick(4);
        rehome_n_i = 1'b1;
        tick(6);
        model = 8;
        check_state("R4 rehome");
        check_val("R9 home flag after rehome", at_home_o, 1);

        // R4 reset mid-run
        step_once(1'b0, 3'b010, "R4 move away");
        check_val("R9 flag away from home", at_home_o, 0);
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(5);
        model = 8;
        check_state("R4 reset returns home");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule